// File: doc/BRIEF.md
# Integer Execution Unit with Condition Flags

This block is the combinational integer datapath of a load/store processor core. Each cycle the issue stage presents an operation code, the destination register's current value, a source operand and a shift amount. The source operand is either a register value or a signed immediate. The issue stage also presents the current carry flag. The block returns the result together with several controls: a register write-enable, a select that sends the result to register 0 instead of the named destination, and a separate update enable for each of the four condition flags (carry, zero, sign, overflow) next to the new flag values.

Addition, subtraction (plain and carry-chained), compare, test, bitwise logic, three shifts, byte and halfword sign-extend and zero-mask, and leading-zero and leading-one counts are covered. Flag registers, the register file, decode, multiply and DSP work sit outside the block. The flag register applies a new flag value only where its enable is high. Compare and test only set flags. The two leading-bit counts always target register 0.

Top module: `int_exec_unit`

## Requirements
- R1: Add (code 0) returns dst+src; add-with-carry (code 1) returns dst+src+carry_in. Both raise the write enable and all four flag enables. Carry is the unsigned carry out and overflow is signed two's-complement overflow.
- R2: Subtract (code 2) returns dst-src; subtract-with-carry (code 3) returns dst-src-carry_in. Carry is 1 when a borrow occurs, and overflow is signed overflow. The write enable and all four flag enables are high.
- R3: Compare (code 4) sets all four flags from dst-src, which is the second assembler operand minus the first. Its write enable is low.
- R4: AND (6), OR (7), XOR (8) and NOT of dst (9) write their result and enable only the zero and sign flag updates.
- R5: Test (code 5) enables only the zero and sign flags, computed from dst AND src. Its write enable is low.
- R6: Arithmetic right shift (10) fills vacated bits with dst bit 31. Logical right shift (11) fills with zero. Left shift (12) fills with zero. The amount is an unsigned 5-bit value.
- R7: A shift enables carry, zero and sign updates, never overflow. Carry is the last bit shifted out. With an amount of 0 the carry enable is low.
- R8: Codes 13 and 14 sign-extend dst bits [7:0] and [15:0]. Codes 15 and 16 mask dst with 0xFF and 0xFFFF. All four enable only the zero and sign flags.
- R9: Code 17 counts leading zeros of dst and code 18 counts leading ones. An all-zero input (code 17) or all-one input (code 18) gives 32. Both write with the register-0 select high and enable only the zero flag.
- R10: When use_imm is 1 the source operand is the 16-bit immediate sign-extended, and src_reg has no effect.
- R11: The zero flag is 1 exactly when the computed value is 0, and the sign flag equals its bit 31.
- R12: Codes 19 to 31 raise neither the write enable nor any flag enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 5 | Operation code |
| dst_val | input | 32 | Destination register value, first data operand |
| src_reg | input | 32 | Source register value |
| imm_val | input | 16 | Signed immediate |
| use_imm | input | 1 | Select immediate as source operand |
| sh_amt | input | 5 | Unsigned shift amount |
| carry_in | input | 1 | Current carry flag |
| result | output | 32 | Computed value |
| wr_en | output | 1 | Register write enable |
| wr_r0 | output | 1 | Redirect the write to register 0 |
| upd_c | output | 1 | Carry flag update enable |
| upd_z | output | 1 | Zero flag update enable |
| upd_s | output | 1 | Sign flag update enable |
| upd_v | output | 1 | Overflow flag update enable |
| flag_c | output | 1 | New carry value |
| flag_z | output | 1 | New zero value |
| flag_s | output | 1 | New sign value |
| flag_v | output | 1 | New overflow value |

## Verification
The bench goes after the places where a sign or borrow convention can silently flip:
- Signed overflow at the 0x7FFFFFFF/0x80000000 boundary, where a wrong overflow formula would report it on the wrong side.
- Subtract-with-carry at zero, where an inverted borrow convention would give carry 0.
- Compare with unequal operands in both orders, where reversed operands would invert carry and sign.

It also probes the shift carry for both directions and for a zero amount, where an indexing error would pick a neighbouring bit or corrupt the carry. The leading-bit counters get all-zero, all-one and single-top-bit inputs, where an off-by-one would return 31 or 1. Every operation's flag-enable pattern is compared in full, so a class that clobbers carry or overflow shows up.

// File: rtl/int_exec_pkg.sv
// Package: operation codes and shared widths for the integer execution unit.
// Assumes a single decode stage produces these codes; values are fixed.
package int_exec_pkg;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_CMP  = 5'd4,
        OP_TST  = 5'd5,
        OP_AND  = 5'd6,
        OP_OR   = 5'd7,
        OP_XOR  = 5'd8,
        OP_NOT  = 5'd9,
        OP_SRA  = 5'd10,
        OP_SRL  = 5'd11,
        OP_SLL  = 5'd12,
        OP_SXB  = 5'd13,
        OP_SXH  = 5'd14,
        OP_ZXB  = 5'd15,
        OP_ZXH  = 5'd16,
        OP_LZC  = 5'd17,
        OP_LOC  = 5'd18
    } exec_op_e;

    typedef enum logic [1:0] {
        SH_ARITH_R = 2'd0,
        SH_LOGIC_R = 2'd1,
        SH_LEFT    = 2'd2
    } shift_mode_e;

endpackage

// File: rtl/exec_addsub.sv
// Module: adder/subtractor with carry (add) or borrow (subtract) out and
// signed overflow. Assumes the caller forces cin to 0 when no chaining.
module exec_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic              cout,
    output logic              ovf
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] wide;

    // Purpose: one extended add or subtract, the top bit gives carry or borrow.
    always_comb begin
        if (sub) begin
            wide = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, cin};
        end else begin
            wide = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
        end
        sum  = wide[DATA_W-1:0];
        cout = wide[DATA_W];
        if (sub) begin
            ovf = (a[MSB] ^ b[MSB]) & (a[MSB] ^ sum[MSB]);
        end else begin
            ovf = ~(a[MSB] ^ b[MSB]) & (a[MSB] ^ sum[MSB]);
        end
    end

endmodule

// File: rtl/exec_shifter.sv
// Module: barrel shifter with three modes; carry is the last bit pushed out.
// Assumes amt below DATA_W; carry output is meaningless for amt of zero.
module exec_shifter #(
    parameter int DATA_W = 32,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]         a,
    input  logic [SH_W-1:0]           amt,
    input  int_exec_pkg::shift_mode_e mode,
    output logic [DATA_W-1:0]         out,
    output logic                      cout
);
    import int_exec_pkg::*;

    // Purpose: select the shifted value and the bit that left last.
    always_comb begin
        out  = a;
        cout = 1'b0;
        case (mode)
            SH_ARITH_R: out = DATA_W'($signed(a) >>> amt);
            SH_LOGIC_R: out = a >> amt;
            default:    out = a << amt;
        endcase
        if (amt != '0) begin
            if (mode == SH_LEFT) begin
                cout = a[DATA_W - int'(amt)];
            end else begin
                cout = a[int'(amt) - 1];
            end
        end
    end

endmodule

// File: rtl/exec_lead_count.sv
// Module: counts leading bits equal to a chosen polarity from the MSB down.
// Returns DATA_W when every bit matches the polarity.
module exec_lead_count #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] a,
    input  logic              find_ones,
    output logic [CNT_W-1:0]  count
);
    logic done;

    // Purpose: scan from the top and stop at the first bit of other polarity.
    always_comb begin
        count = CNT_W'(DATA_W);
        done  = 1'b0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            if (!done && (a[i] != find_ones)) begin
                count = CNT_W'(DATA_W - 1 - i);
                done  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/int_exec_unit.sv
// Module: combinational integer execution unit. Decodes the operation, picks
// the source operand, routes the sub-unit outputs and issues write and per-flag
// update enables. Assumes the flag register applies only enabled flags.
module int_exec_unit #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int SH_W   = $clog2(DATA_W),
    parameter int CNT_W  = $clog2(DATA_W + 1)
) (
    input  logic [4:0]        op,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [DATA_W-1:0] src_reg,
    input  logic [IMM_W-1:0]  imm_val,
    input  logic              use_imm,
    input  logic [SH_W-1:0]   sh_amt,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic              wr_en,
    output logic              wr_r0,
    output logic              upd_c,
    output logic              upd_z,
    output logic              upd_s,
    output logic              upd_v,
    output logic              flag_c,
    output logic              flag_z,
    output logic              flag_s,
    output logic              flag_v
);
    import int_exec_pkg::*;

    localparam int MSB = DATA_W - 1;
    localparam logic [DATA_W-1:0] FULL_CNT = DATA_W;

    exec_op_e          op_e;
    logic [DATA_W-1:0] src_op;
    logic              as_sub;
    logic              as_cin;
    logic [DATA_W-1:0] as_sum;
    logic              as_cout;
    logic              as_ovf;
    shift_mode_e       sh_mode;
    logic [DATA_W-1:0] sh_out;
    logic              sh_cout;
    logic              lc_ones;
    logic [CNT_W-1:0]  lc_cnt;

    // Purpose: choose register or sign-extended immediate as source operand.
    always_comb begin
        op_e   = exec_op_e'(op);
        src_op = use_imm ? {{(DATA_W-IMM_W){imm_val[IMM_W-1]}}, imm_val} : src_reg;
    end

    // Purpose: steer sub-unit controls from the operation code.
    always_comb begin
        as_sub  = (op_e == OP_SUB) || (op_e == OP_SBC) || (op_e == OP_CMP);
        as_cin  = ((op_e == OP_ADC) || (op_e == OP_SBC)) ? carry_in : 1'b0;
        lc_ones = (op_e == OP_LOC);
        case (op_e)
            OP_SRA:  sh_mode = SH_ARITH_R;
            OP_SRL:  sh_mode = SH_LOGIC_R;
            default: sh_mode = SH_LEFT;
        endcase
    end

    exec_addsub #(.DATA_W(DATA_W)) addsub_i (
        .a(dst_val), .b(src_op), .cin(as_cin), .sub(as_sub),
        .sum(as_sum), .cout(as_cout), .ovf(as_ovf)
    );

    exec_shifter #(.DATA_W(DATA_W), .SH_W(SH_W)) shifter_i (
        .a(dst_val), .amt(sh_amt), .mode(sh_mode),
        .out(sh_out), .cout(sh_cout)
    );

    exec_lead_count #(.DATA_W(DATA_W), .CNT_W(CNT_W)) lead_i (
        .a(dst_val), .find_ones(lc_ones), .count(lc_cnt)
    );

    // Purpose: result mux and per-class write and flag-enable pattern.
    always_comb begin
        result = '0;
        wr_en  = 1'b0;
        wr_r0  = 1'b0;
        upd_c  = 1'b0;
        upd_z  = 1'b0;
        upd_s  = 1'b0;
        upd_v  = 1'b0;
        flag_c = 1'b0;
        flag_v = 1'b0;
        case (op_e)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP: begin
                result = as_sum;
                wr_en  = (op_e != OP_CMP);
                {upd_c, upd_z, upd_s, upd_v} = 4'b1111;
                flag_c = as_cout;
                flag_v = as_ovf;
            end
            OP_TST, OP_AND: begin
                result = dst_val & src_op;
                wr_en  = (op_e == OP_AND);
                {upd_z, upd_s} = 2'b11;
            end
            OP_OR: begin
                result = dst_val | src_op;
                wr_en  = 1'b1;
                {upd_z, upd_s} = 2'b11;
            end
            OP_XOR: begin
                result = dst_val ^ src_op;
                wr_en  = 1'b1;
                {upd_z, upd_s} = 2'b11;
            end
            OP_NOT: begin
                result = ~dst_val;
                wr_en  = 1'b1;
                {upd_z, upd_s} = 2'b11;
            end
            OP_SRA, OP_SRL, OP_SLL: begin
                result = sh_out;
                wr_en  = 1'b1;
                upd_c  = (sh_amt != '0);
                {upd_z, upd_s} = 2'b11;
                flag_c = sh_cout;
            end
            OP_SXB, OP_SXH, OP_ZXB, OP_ZXH: begin
                case (op_e)
                    OP_SXB:  result = {{(DATA_W-8){dst_val[7]}}, dst_val[7:0]};
                    OP_SXH:  result = {{(DATA_W-16){dst_val[15]}}, dst_val[15:0]};
                    OP_ZXB:  result = {{(DATA_W-8){1'b0}}, dst_val[7:0]};
                    default: result = {{(DATA_W-16){1'b0}}, dst_val[15:0]};
                endcase
                wr_en = 1'b1;
                {upd_z, upd_s} = 2'b11;
            end
            OP_LZC, OP_LOC: begin
                result = {{(DATA_W-CNT_W){1'b0}}, lc_cnt};
                wr_en  = 1'b1;
                wr_r0  = 1'b1;
                upd_z  = 1'b1;
            end
            default: ;
        endcase
        flag_z = (result == '0);
        flag_s = result[MSB];
    end

    // Purpose: guard the sub-unit outputs against the operation contract.
    always_comb begin
        if (op_e == OP_ADD) begin
            assert_add_inverse_R1: assert ((result - src_op) == dst_val)
                else $error("add result does not invert");
        end
        if (op_e == OP_CMP) begin
            assert_cmp_nowrite_R3: assert (!wr_en && upd_c && upd_v)
                else $error("compare wrote or skipped flags");
        end
        if (op_e inside {OP_AND, OP_OR, OP_XOR, OP_NOT, OP_TST}) begin
            assert_logic_keeps_cv_R4: assert (!upd_c && !upd_v)
                else $error("logic op touched carry or overflow");
        end
        if ((op_e == OP_SRL) && (sh_amt != '0)) begin
            assert_srl_zero_fill_R6: assert (result[MSB] == 1'b0)
                else $error("logical shift filled a one");
        end
        if (op_e == OP_SRA) begin
            assert_sra_sign_fill_R6: assert (result[MSB] == dst_val[MSB])
                else $error("arithmetic shift lost the sign");
        end
        if (op_e inside {OP_SRA, OP_SRL, OP_SLL}) begin
            assert_shift_no_v_R7: assert (!upd_v)
                else $error("shift touched overflow");
        end
        if (op_e inside {OP_LZC, OP_LOC}) begin
            assert_lead_range_R9: assert ((result <= FULL_CNT) && wr_r0 && !upd_s)
                else $error("leading count out of contract");
        end
    end

endmodule

// File: tb/int_exec_unit_tb.sv
// Bench: directed scenarios, one task each, checking at the ports.
module int_exec_unit_tb_top;
    import int_exec_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op = '0;
    logic [31:0] dst_val = '0;
    logic [31:0] src_reg = '0;
    logic [15:0] imm_val = '0;
    logic        use_imm = 1'b0;
    logic [4:0]  sh_amt = '0;
    logic        carry_in = 1'b0;
    logic [31:0] result;
    logic        wr_en, wr_r0, upd_c, upd_z, upd_s, upd_v;
    logic        flag_c, flag_z, flag_s, flag_v;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    int_exec_unit dut_i (
        .op(op), .dst_val(dst_val), .src_reg(src_reg), .imm_val(imm_val),
        .use_imm(use_imm), .sh_amt(sh_amt), .carry_in(carry_in),
        .result(result), .wr_en(wr_en), .wr_r0(wr_r0),
        .upd_c(upd_c), .upd_z(upd_z), .upd_s(upd_s), .upd_v(upd_v),
        .flag_c(flag_c), .flag_z(flag_z), .flag_s(flag_s), .flag_v(flag_v)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive on the falling edge and let the combinational paths settle.
    task automatic apply(input exec_op_e o, input logic [31:0] d, input logic [31:0] s,
                         input logic [15:0] im, input logic ui, input logic [4:0] sa,
                         input logic ci);
        @(negedge clk);
        op = o; dst_val = d; src_reg = s; imm_val = im;
        use_imm = ui; sh_amt = sa; carry_in = ci;
        #1;
    endtask

    // Enables packed {wr_en, wr_r0, upd_c, upd_z, upd_s, upd_v}; flags {c,z,s,v}.
    task automatic expect_all(input string req, input logic [31:0] res,
                              input logic [5:0] en, input logic [3:0] fl,
                              input logic [3:0] fl_mask);
        chk(req, "result", result, res);
        chk(req, "enables", {26'd0, wr_en, wr_r0, upd_c, upd_z, upd_s, upd_v}, {26'd0, en});
        chk(req, "flags", {28'd0, {flag_c, flag_z, flag_s, flag_v} & fl_mask},
            {28'd0, fl & fl_mask});
    endtask

    task automatic t_idle;
        apply(OP_ADD, 32'd0, 32'd0, 16'd0, 1'b0, 5'd0, 1'b0);
        expect_all("R11", 32'd0, 6'b101111, 4'b0100, 4'b1111);
    endtask

    task automatic t_add_R1;
        apply(OP_ADD, 32'h7FFF_FFFF, 32'd1, 16'd0, 1'b0, 5'd0, 1'b0);
        expect_all("R1", 32'h8000_0000, 6'b101111, 4'b0011, 4'b1111);
        apply(OP_ADD, 32'hFFFF_FFFF, 32'd1, 16'd0, 1'b0, 5'd0, 1'b1);
        expect_all("R1", 32'd0, 6'b101111, 4'b1100, 4'b1111);
        apply(OP_ADC, 32'd5, 32'd3, 16'd0, 1'b0, 5'd0, 1'b1);
        expect_all("R1", 32'd9, 6'b101111, 4'b0000, 4'b1111);
    endtask

    task automatic t_sub_R2;
        apply(OP_SUB, 32'd3, 32'd5, 16'd0, 1'b0, 5'd0, 1'b0);
        expect_all("R2", 32'hFFFF_FFFE, 6'b101111, 4'b1010, 4'b1111);
        apply(OP_SUB, 32'h8000_0000, 32'd1, 16'd0, 1'b0, 5'd0, 1'b1);
        expect_all("R2", 32'h7FFF_FFFF, 6'b101111, 4'b0001, 4'b1111);
        apply(OP_SBC, 32'd10, 32'd3, 16'd0, 1'b0, 5'd0, 1'b1);
        expect_all("R2", 32'd6, 6'b101111, 4'b0000, 4'b1111);
        apply(OP_SBC, 32'd0, 32'd0, 16'd0, 1'b0, 5'd0, 1'b1);
        expect_all("R2", 32'hFFFF_FFFF, 6'b101111, 4'b1010, 4'b1111);
    endtask

    task automatic t_cmp_R3;
        apply(OP_CMP, 32'd5, 32'd5, 16'd0, 1'b0, 5'd0, 1'b0);
        expect_all("R3", 32'd0, 6'b001111, 4'b0100, 4'b1111);
        apply(OP_CMP, 32'd2, 32'd7, 16'd0, 1'b0, 5'd0, 1'b0);
        expect_all("R3", 32'hFFFF_FFFB, 6'b001111, 4'b1010, 4'b1111);
        apply(OP_CMP, 32'd7, 32'd2, 16'd0, 1'b0, 5'd0, 1'b1);
        expect_all("R3", 32'd5, 6'b001111, 4'b0000, 4'b1111);
    endtask

    task automatic t_logic_R4;
        apply(OP_AND, 32'h0000_F0F0, 32'h0000_0FF0, 16'd0, 1'b0, 5'd0, 1'b1);
        expect_all("R4", 32'h0000_00F0, 6'b100110, 4'b0000, 4'b0110);
        apply(OP_OR, 32'h8000_0000, 32'h0000_0001, 16'd0, 1'b0, 5'd0, 1'b0);
        expect_all("R4", 32'h8000_0001, 6'b100110, 4'b0010, 4'b0110);
        apply(OP_XOR, 32'h1234_5678, 32'h1234_5678, 16'd0, 1'b0, 5'd0, 1'b0);
        expect_all("R4", 32'd0, 6'b100110, 4'b0100, 4'b0110);
        apply(OP_NOT, 32'd0, 32'h5555_5555, 16'd0, 1'b0, 5'd0, 1'b0);
        expect_all("R4", 32'hFFFF_FFFF, 6'b100110, 4'b0010, 4'b0110);
    endtask

    task automatic t_tst_R5;
        apply(OP_TST, 32'h0000_00F0, 32'h0000_000F, 16'd0, 1'b0, 5'd0, 1'b1);
        expect_all("R5", 32'd0, 6'b000110, 4'b0100, 4'b0110);
        apply(OP_TST, 32'hF000_0000, 32'h8000_0000, 16'd0, 1'b0, 5'd0, 1'b0);
        expect_all("R5", 32'h8000_0000, 6'b000110, 4'b0010, 4'b0110);
    endtask

    task automatic t_shift_R6_R7;
        apply(OP_SRA, 32'h8000_0010, 32'd0, 16'd0, 1'b0, 5'd4, 1'b1);
        expect_all("R6", 32'hF800_0001, 6'b101110, 4'b0010, 4'b1110);
        apply(OP_SRL, 32'h8000_0018, 32'd0, 16'd0, 1'b0, 5'd4, 1'b0);
        expect_all("R7", 32'h0800_0001, 6'b101110, 4'b1000, 4'b1110);
        apply(OP_SLL, 32'hC000_0000, 32'd0, 16'd0, 1'b0, 5'd1, 1'b0);
        expect_all("R7", 32'h8000_0000, 6'b101110, 4'b1010, 4'b1110);
        apply(OP_SLL, 32'hC000_0000, 32'd0, 16'd0, 1'b0, 5'd2, 1'b0);
        expect_all("R7", 32'd0, 6'b101110, 4'b1100, 4'b1110);
        apply(OP_SRL, 32'h0000_00FF, 32'd0, 16'd0, 1'b0, 5'd0, 1'b1);
        expect_all("R7", 32'h0000_00FF, 6'b100110, 4'b0000, 4'b0110);
        apply(OP_SRA, 32'h7FFF_FFFF, 32'd0, 16'd0, 1'b0, 5'd31, 1'b0);
        expect_all("R6", 32'd0, 6'b101110, 4'b1100, 4'b1110);
    endtask

    task automatic t_ext_R8;
        apply(OP_SXB, 32'h1234_5680, 32'd0, 16'd0, 1'b0, 5'd0, 1'b1);
        expect_all("R8", 32'hFFFF_FF80, 6'b100110, 4'b0010, 4'b0110);
        apply(OP_SXH, 32'h0000_8001, 32'd0, 16'd0, 1'b0, 5'd0, 1'b0);
        expect_all("R8", 32'hFFFF_8001, 6'b100110, 4'b0010, 4'b0110);
        apply(OP_ZXB, 32'hABCD_EF12, 32'd0, 16'd0, 1'b0, 5'd0, 1'b0);
        expect_all("R8", 32'h0000_0012, 6'b100110, 4'b0000, 4'b0110);
        apply(OP_ZXH, 32'hABCD_0000, 32'd0, 16'd0, 1'b0, 5'd0, 1'b0);
        expect_all("R8", 32'd0, 6'b100110, 4'b0100, 4'b0110);
    endtask

    task automatic t_count_R9;
        apply(OP_LZC, 32'd0, 32'd0, 16'd0, 1'b0, 5'd0, 1'b0);
        expect_all("R9", 32'd32, 6'b110100, 4'b0000, 4'b0100);
        apply(OP_LZC, 32'h0001_0000, 32'd0, 16'd0, 1'b0, 5'd0, 1'b0);
        expect_all("R9", 32'd15, 6'b110100, 4'b0000, 4'b0100);
        apply(OP_LZC, 32'h8000_0000, 32'd0, 16'd0, 1'b0, 5'd0, 1'b0);
        expect_all("R9", 32'd0, 6'b110100, 4'b0100, 4'b0100);
        apply(OP_LOC, 32'hFFFF_FFFF, 32'd0, 16'd0, 1'b0, 5'd0, 1'b0);
        expect_all("R9", 32'd32, 6'b110100, 4'b0000, 4'b0100);
        apply(OP_LOC, 32'hF000_0000, 32'd0, 16'd0, 1'b0, 5'd0, 1'b0);
        expect_all("R9", 32'd4, 6'b110100, 4'b0000, 4'b0100);
        apply(OP_LOC, 32'h7FFF_FFFF, 32'd0, 16'd0, 1'b0, 5'd0, 1'b0);
        expect_all("R9", 32'd0, 6'b110100, 4'b0100, 4'b0100);
    endtask

    task automatic t_imm_R10;
        apply(OP_ADD, 32'd10, 32'h0000_0100, 16'hFFFF, 1'b1, 5'd0, 1'b0);
        expect_all("R10", 32'd9, 6'b101111, 4'b1000, 4'b1111);
        apply(OP_OR, 32'd0, 32'hFFFF_0000, 16'h7001, 1'b1, 5'd0, 1'b0);
        expect_all("R10", 32'h0000_7001, 6'b100110, 4'b0000, 4'b0110);
    endtask

    task automatic t_unused_R12;
        for (int c = 19; c < 32; c += 6) begin
            @(negedge clk);
            op = 5'(c); dst_val = 32'h1111_2222; src_reg = 32'h3; use_imm = 1'b0;
            #1;
            chk("R12", "enables", {26'd0, wr_en, wr_r0, upd_c, upd_z, upd_s, upd_v}, 32'd0);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_add_R1();
        t_sub_R2();
        t_cmp_R3();
        t_logic_R4();
        t_tst_R5();
        t_shift_R6_R7();
        t_ext_R8();
        t_count_R9();
        t_imm_R10();
        t_unused_R12();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule